// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the software-facing front end of one eight-line interrupt controller. It sits on a small 8-bit bus with two addresses. A write to address 0 is one of three things, chosen by data bits 4 and 3: the start of initialization, a control word, or a service command. A write to address 1 either loads the interrupt mask or feeds the initialization sequencer. The block holds the mask, in-service, rotation-base, vector-base and mode registers. It applies end-of-interrupt and rotation commands to the in-service and base registers, and it answers status and poll reads.

The priority resolver is a separate block. It reports whether a line should be raised (`res_hit`) and which line (`res_line`), and this block uses that report for poll reads and acknowledge strobes. The request register is also kept outside. This block reads its contents on `req_vec` and returns one-hot clear pulses on `req_clr` when a poll read consumes a line. Cascade acknowledge is not part of this block.

All bus accesses take one clock. Read data is produced combinationally while `bus_rd` is high, and every register change from a read or write shows from the next cycle. The bus uses plain single-cycle strobes with no back-pressure: every access is accepted in the cycle it is presented.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset the mask, in-service, rotation base, vector base, all mode flags, poll arm and read select are zero, and the init sequencer is idle (`init_busy` = 0).
- R2: A write to address 0 with data bit 4 set pulses `intr_drop` in the same cycle. From the next cycle it clears mask, in-service, base, vector base, auto-EOI, rotate-on-auto-EOI, nested mode, special mask, poll arm and read select. It stores data bit 0 as the "fourth word needed" flag and sets `init_busy` (the sequencer waits for the vector base).
- R3: While initialization runs, address-1 writes step the sequencer. The first loads `vector_base` with data AND 0xF8. The second ends the sequence if no fourth word is needed. Otherwise a third write ends it and takes data bit 4 as `nested_mode` and data bit 1 as `auto_eoi`. `init_busy` is 1 until the sequence ends.
- R4: When the sequencer is idle, an address-1 write loads `irq_mask`. An address-1 read without poll returns the mask.
- R5: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a control word. If bit 1 is set, bit 0 selects what address-0 reads return: 1 = in-service, 0 = `req_vec`. If bit 1 is clear, the selection is kept.
- R6: In a control word, data bit 6 = 1 loads `special_mask` from data bit 5. With bit 6 = 0 the flag is kept.
- R7: Priority runs from the line in `prio_base` upward modulo 8, and the base line is highest. Command 1 (data bits 7:5 = 001, bits 4:3 = 00) clears the highest-priority in-service bit. If no in-service bit is set, it leaves in-service and base unchanged.
- R8: Command 5 clears the highest-priority in-service bit and sets the base to that line + 1 modulo 8. With nothing in service it changes nothing.
- R9: Command 3 clears in-service bit data[2:0]. Command 6 sets the base to data[2:0] + 1 modulo 8. Command 7 does both. Command 2 changes no state.
- R10: Commands 0 and 4 load `rot_auto_eoi` with command bit 2 (0 and 1 respectively).
- R11: An `ack_stb` pulse sets in-service bit `res_line` when `auto_eoi` = 0. When `auto_eoi` = 1 it leaves in-service unchanged, and if `rot_auto_eoi` = 1 it sets the base to `res_line` + 1 modulo 8.
- R12: A control word with bit 2 set arms poll. The next read (either address) returns `res_line` when `res_hit` = 1, pulses `req_clr` at that line and clears that in-service bit. It returns 7 with no clear when `res_hit` = 0. Poll is then disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| res_hit | input | 1 | Resolver reports a line to raise |
| res_line | input | 3 | Line chosen by the resolver |
| req_vec | input | 8 | Contents of the external request register |
| ack_stb | input | 1 | Acknowledge of line res_line |
| req_clr | output | 8 | One-hot request clear from a poll read |
| intr_drop | output | 1 | Pulse: drop the interrupt output (initialization start) |
| irq_mask | output | 8 | Mask register |
| in_service | output | 8 | In-service register |
| prio_base | output | 3 | Highest-priority line (rotation base) |
| vector_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on auto end-of-interrupt |
| nested_mode | output | 1 | Fully nested mode flag |
| special_mask | output | 1 | Special mask flag |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
The bench builds the block with its default parameters: eight lines and an 8-bit data path. With eight lines every command code is reachable. Rotation can be driven across the wrap from line 7 to line 0, and a rotated base can be set so that the highest in-service bit is not the lowest-numbered one. The 8-bit width allows full mask patterns and the vector-base truncation of the low three bits. Both initialization lengths, poll with and without a pending line, and auto-EOI acknowledges with rotation on are all run against values computed from the requirements.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_VBASE  = 2'd1,
    SEQ_THIRD  = 2'd2,
    SEQ_FOURTH = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_e;

  typedef struct packed {
    logic init;
    logic ctl;
    logic cmd;
    logic reg_wr;
    op_e  op;
  } wr_kind_t;

endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output wr_kind_t      kind
);

  logic a0_wr;

  always_comb begin
    a0_wr       = wr && !addr;
    kind.init   = a0_wr && wdata[4];
    kind.ctl    = a0_wr && !wdata[4] && wdata[3];
    kind.cmd    = a0_wr && !wdata[4] && !wdata[3];
    kind.reg_wr = wr && addr;
    kind.op     = op_e'(wdata[7:5]);
  end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8,
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_go,
  input  logic          reg_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] vbase_q,
  output logic          aeoi_q,
  output logic          nested_q,
  output logic          busy
);

  localparam logic [DW-1:0] VB_KEEP = ~DW'(LINES - 1);

  seq_state_e state_q;
  logic       need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      need4_q  <= 1'b0;
      mask_q   <= '0;
      vbase_q  <= '0;
      aeoi_q   <= 1'b0;
      nested_q <= 1'b0;
    end else if (init_go) begin
      state_q  <= SEQ_VBASE;
      need4_q  <= wdata[0];
      mask_q   <= '0;
      vbase_q  <= '0;
      aeoi_q   <= 1'b0;
      nested_q <= 1'b0;
    end else if (reg_wr) begin
      case (state_q)
        SEQ_IDLE:   mask_q <= wdata;
        SEQ_VBASE: begin
          vbase_q <= wdata & VB_KEEP;
          state_q <= SEQ_THIRD;
        end
        SEQ_THIRD:  state_q <= need4_q ? SEQ_FOURTH : SEQ_IDLE;
        SEQ_FOURTH: begin
          nested_q <= wdata[4];
          aeoi_q   <= wdata[1];
          state_q  <= SEQ_IDLE;
        end
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q != SEQ_IDLE);

  // R2
  init_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> (state_q == SEQ_VBASE) && (mask_q == '0));

  // R3
  vbase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !init_go && state_q == SEQ_VBASE) |=>
      (vbase_q[LW-1:0] == '0) && (state_q == SEQ_THIRD));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !init_go && state_q == SEQ_IDLE) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic_cmd_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_go,
  input  logic             cmd_go,
  input  op_e              op,
  input  logic [LW-1:0]    cmd_line,
  input  logic             ack_stb,
  input  logic [LW-1:0]    ack_line,
  input  logic             aeoi,
  input  logic             poll_clr,
  input  logic [LW-1:0]    poll_line,
  output logic [LINES-1:0] isr_q,
  output logic [LW-1:0]    base_q,
  output logic             rot_q
);

  logic [LINES-1:0] isr_n;
  logic [LW-1:0]    base_n;
  logic             rot_n;
  logic             hi_found;
  logic [LW-1:0]    hi_line;
  logic [LW-1:0]    scan_idx;

  // rotating scan: first set in-service bit from base upward
  always_comb begin
    hi_found = 1'b0;
    hi_line  = '0;
    scan_idx = '0;
    for (int k = 0; k < LINES; k++) begin
      scan_idx = base_q + LW'(k);
      if (!hi_found && isr_q[scan_idx]) begin
        hi_found = 1'b1;
        hi_line  = scan_idx;
      end
    end
  end

  always_comb begin
    isr_n  = isr_q;
    base_n = base_q;
    rot_n  = rot_q;
    if (cmd_go) begin
      case (op)
        OP_ROT_CLR: rot_n = 1'b0;
        OP_ROT_SET: rot_n = 1'b1;
        OP_EOI: if (hi_found) isr_n[hi_line] = 1'b0;
        OP_REOI: if (hi_found) begin
          isr_n[hi_line] = 1'b0;
          base_n         = hi_line + LW'(1);
        end
        OP_SEOI:   isr_n[cmd_line] = 1'b0;
        OP_SETPRI: base_n = cmd_line + LW'(1);
        OP_RSEOI: begin
          isr_n[cmd_line] = 1'b0;
          base_n          = cmd_line + LW'(1);
        end
        default: ;
      endcase
    end
    if (poll_clr) isr_n[poll_line] = 1'b0;
    if (ack_stb) begin
      if (!aeoi)      isr_n[ack_line] = 1'b1;
      else if (rot_q) base_n = ack_line + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_go) begin
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      isr_q  <= isr_n;
      base_q <= base_n;
      rot_q  <= rot_n;
    end
  end

  // R7
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (op == OP_EOI || op == OP_REOI) && isr_q == '0 && !ack_stb)
      |=> ($stable(isr_q) && $stable(base_q)));

  // R9
  seoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (op == OP_SEOI || op == OP_RSEOI) && !ack_stb)
      |=> !isr_q[$past(cmd_line)]);

  // R9
  setpri_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_SETPRI && !ack_stb)
      |=> (base_q == $past(cmd_line) + LW'(1)));

  // R11
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !aeoi && !init_go) |=> isr_q[$past(ack_line)]);

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LINES = 8,
  localparam int LW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             res_hit,
  input  logic [LW-1:0]    res_line,
  input  logic [LINES-1:0] req_vec,
  input  logic             ack_stb,
  output logic [LINES-1:0] req_clr,
  output logic             intr_drop,
  output logic [DW-1:0]    irq_mask,
  output logic [LINES-1:0] in_service,
  output logic [LW-1:0]    prio_base,
  output logic [DW-1:0]    vector_base,
  output logic             auto_eoi,
  output logic             rot_auto_eoi,
  output logic             nested_mode,
  output logic             special_mask,
  output logic             init_busy
);

  wr_kind_t kind;
  logic     poll_armed;
  logic     rd_isr_sel;
  logic     smm_q;
  logic     poll_take;
  logic     poll_clr;

  pic_wr_decode #(.DW(DW)) u_dec (
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .kind  (kind)
  );

  pic_init_seq #(.DW(DW), .LINES(LINES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_go  (kind.init),
    .reg_wr   (kind.reg_wr),
    .wdata    (bus_wdata),
    .mask_q   (irq_mask),
    .vbase_q  (vector_base),
    .aeoi_q   (auto_eoi),
    .nested_q (nested_mode),
    .busy     (init_busy)
  );

  pic_service #(.LINES(LINES)) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_go   (kind.init),
    .cmd_go    (kind.cmd),
    .op        (kind.op),
    .cmd_line  (bus_wdata[LW-1:0]),
    .ack_stb   (ack_stb),
    .ack_line  (res_line),
    .aeoi      (auto_eoi),
    .poll_clr  (poll_clr),
    .poll_line (res_line),
    .isr_q     (in_service),
    .base_q    (prio_base),
    .rot_q     (rot_auto_eoi)
  );

  assign poll_take = bus_rd && poll_armed;
  assign poll_clr  = poll_take && res_hit;
  assign intr_drop = kind.init;

  always_ff @(posedge clk) begin
    if (!rst_n || kind.init) begin
      poll_armed <= 1'b0;
      rd_isr_sel <= 1'b0;
      smm_q      <= 1'b0;
    end else begin
      if (kind.ctl) begin
        if (bus_wdata[2]) poll_armed <= 1'b1;
        if (bus_wdata[1]) rd_isr_sel <= bus_wdata[0];
        if (bus_wdata[6]) smm_q      <= bus_wdata[5];
      end
      if (poll_take) poll_armed <= 1'b0;
    end
  end

  assign special_mask = smm_q;

  always_comb begin
    req_clr = '0;
    if (poll_clr) req_clr = LINES'(1) << res_line;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (poll_armed)
        bus_rdata = res_hit ? DW'(res_line) : DW'(LINES - 1);
      else if (bus_addr)
        bus_rdata = irq_mask;
      else
        bus_rdata = rd_isr_sel ? DW'(in_service) : DW'(req_vec);
    end
  end

  // R12
  poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !kind.ctl) |=> !poll_armed);

  // R12
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_clr && !ack_stb) |=> !in_service[$past(res_line)]);

  // R2
  init_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_drop |=> (in_service == '0) && (prio_base == '0) && !special_mask && init_busy);

endmodule

// File: tb/tb_pic_cmd_port.sv
`timescale 1ns/1ps
module tb_pic_cmd_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       res_hit;
  logic [2:0] res_line;
  logic [7:0] req_vec;
  logic       ack_stb;
  logic [7:0] req_clr;
  logic       intr_drop;
  logic [7:0] irq_mask, in_service, vector_base;
  logic [2:0] prio_base;
  logic       auto_eoi, rot_auto_eoi, nested_mode, special_mask, init_busy;

  int nvec = 0;
  int nbad = 0;
  logic       last_drop;
  logic [7:0] rd_val, rd_clr;

  always #2.5 clk = ~clk;

  pic_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_hit(res_hit), .res_line(res_line),
    .req_vec(req_vec), .ack_stb(ack_stb), .req_clr(req_clr), .intr_drop(intr_drop),
    .irq_mask(irq_mask), .in_service(in_service), .prio_base(prio_base),
    .vector_base(vector_base), .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
    .nested_mode(nested_mode), .special_mask(special_mask), .init_busy(init_busy)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 last_drop = intr_drop;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 begin rd_val = bus_rdata; rd_clr = req_clr; end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk);
    res_line = l; ack_stb = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mask", irq_mask, 8'h00);
    chk("R1 isr", in_service, 8'h00);
    chk("R1 base", {5'd0, prio_base}, 8'h00);
    chk("R1 busy", {7'd0, init_busy}, 8'h00);
    chk("R1 vbase", vector_base, 8'h00);
    rd(1'b1);
    chk("R1 read mask", rd_val, 8'h00);
  endtask

  task automatic t_init_four();
    wr(1'b0, 8'h11);
    chk("R2 drop pulse", {7'd0, last_drop}, 8'h01);
    chk("R2 busy", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h4D);
    chk("R3 vbase", vector_base, 8'h48);
    wr(1'b1, 8'h00);
    chk("R3 still busy", {7'd0, init_busy}, 8'h01);
    wr(1'b1, 8'h12);
    chk("R3 done", {7'd0, init_busy}, 8'h00);
    chk("R3 aeoi", {7'd0, auto_eoi}, 8'h01);
    chk("R3 nested", {7'd0, nested_mode}, 8'h01);
    wr(1'b1, 8'hA5);
    chk("R4 mask", irq_mask, 8'hA5);
    rd(1'b1);
    chk("R4 read mask", rd_val, 8'hA5);
  endtask

  task automatic t_init_three();
    wr(1'b0, 8'h10);
    chk("R2 mask cleared", irq_mask, 8'h00);
    chk("R2 aeoi cleared", {7'd0, auto_eoi}, 8'h00);
    wr(1'b1, 8'h21);
    chk("R3 vbase trunc", vector_base, 8'h20);
    wr(1'b1, 8'h00);
    chk("R3 three word done", {7'd0, init_busy}, 8'h00);
    wr(1'b1, 8'h3C);
    chk("R4 mask after 3", irq_mask, 8'h3C);
  endtask

  task automatic t_status();
    req_vec = 8'h81;
    ack(3'd3); ack(3'd5);
    chk("R11 ack sets isr", in_service, 8'h28);
    rd(1'b0);
    chk("R5 read req", rd_val, 8'h81);
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R5 read isr", rd_val, 8'h28);
    wr(1'b0, 8'h09);
    rd(1'b0);
    chk("R5 select kept", rd_val, 8'h28);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R5 back to req", rd_val, 8'h81);
  endtask

  task automatic t_eoi();
    wr(1'b0, 8'h20);
    chk("R7 clear highest", in_service, 8'h20);
    wr(1'b0, 8'h20);
    chk("R7 clear next", in_service, 8'h00);
    wr(1'b0, 8'h20);
    chk("R7 empty isr", in_service, 8'h00);
    chk("R7 empty base", {5'd0, prio_base}, 8'h00);
    wr(1'b0, 8'hA0);
    chk("R8 empty base", {5'd0, prio_base}, 8'h00);
  endtask

  task automatic t_rotate();
    wr(1'b0, 8'hC4);
    chk("R9 set prio", {5'd0, prio_base}, 8'h05);
    ack(3'd2); ack(3'd6);
    wr(1'b0, 8'h20);
    chk("R7 rotated order", in_service, 8'h04);
    ack(3'd6);
    wr(1'b0, 8'hA0);
    chk("R8 rot eoi isr", in_service, 8'h04);
    chk("R8 rot eoi base", {5'd0, prio_base}, 8'h07);
    wr(1'b0, 8'h40);
    chk("R9 nop isr", in_service, 8'h04);
    chk("R9 nop base", {5'd0, prio_base}, 8'h07);
    wr(1'b0, 8'h62);
    chk("R9 specific eoi", in_service, 8'h00);
    ack(3'd1);
    wr(1'b0, 8'hE1);
    chk("R9 rot specific isr", in_service, 8'h00);
    chk("R9 rot specific base", {5'd0, prio_base}, 8'h02);
    wr(1'b0, 8'hC7);
    chk("R9 wrap", {5'd0, prio_base}, 8'h00);
  endtask

  task automatic t_rot_aeoi();
    wr(1'b0, 8'h80);
    chk("R10 set", {7'd0, rot_auto_eoi}, 8'h01);
    wr(1'b0, 8'h00);
    chk("R10 clear", {7'd0, rot_auto_eoi}, 8'h00);
    wr(1'b0, 8'h80);
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    chk("R2 rot cleared", {7'd0, rot_auto_eoi}, 8'h00);
    wr(1'b0, 8'h80);
    ack(3'd4);
    chk("R11 aeoi no isr", in_service, 8'h00);
    chk("R11 aeoi rotate", {5'd0, prio_base}, 8'h05);
  endtask

  task automatic t_poll();
    wr(1'b0, 8'h10); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    wr(1'b1, 8'h5A);
    ack(3'd4);
    wr(1'b0, 8'h0C);
    res_hit = 1'b1; res_line = 3'd4;
    rd(1'b1);
    chk("R12 poll data", rd_val, 8'h04);
    chk("R12 poll clr", rd_clr, 8'h10);
    chk("R12 isr cleared", in_service, 8'h00);
    rd(1'b1);
    chk("R12 disarmed", rd_val, 8'h5A);
    chk("R12 no clr", rd_clr, 8'h00);
    wr(1'b0, 8'h0C);
    res_hit = 1'b0;
    rd(1'b0);
    chk("R12 none pending", rd_val, 8'h07);
    chk("R12 none clr", rd_clr, 8'h00);
  endtask

  task automatic t_smm();
    wr(1'b0, 8'h68);
    chk("R6 set", {7'd0, special_mask}, 8'h01);
    wr(1'b0, 8'h28);
    chk("R6 kept", {7'd0, special_mask}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R6 clear", {7'd0, special_mask}, 8'h00);
  endtask

  initial begin
    #500000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    res_hit = 1'b0; res_line = 3'd0; req_vec = 8'h00; ack_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_four();
    t_init_three();
    t_status();
    t_eoi();
    t_rotate();
    t_rot_aeoi();
    t_poll();
    t_smm();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule